// File: doc/BRIEF.md
# Two-Sequencer Interrupt Flag Controller

This block collects event pulses from two independent serial data sequencers and turns them into sticky status flags with one shared interrupt line. Each sequencer reports four kinds of event: a received word is waiting, a received word was lost (overrun), the transmitter can take a new word, and the transmitter ran dry (underrun). Every event pulse sets its own bit in a 16-bit status register. The bit stays set until software clears it.

Software clears a flag by writing a one to its bit. The two "ready" flags of each sequencer also clear as a side effect of a data access. Reading the sequencer's data register clears its receive-ready flag. Writing the data register clears its transmit-ready flag. A 16-bit enable mask chooses which flags can raise the interrupt. Software reaches the mask through two register views: one view sets bits and the other clears them. The interrupt output is registered.

The register bus is synchronous and single-cycle. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low. The sequencers deliver all events and data-access strobes as one-cycle pulses.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset, the status register and the enable mask both read 0x0000, and `irq` is low.
- R2: An event pulse sets its status bit on the next clock edge. The status register sits at offset 0x14. Bit positions are receive-ready at bit 0+s, overrun at bit 4+s, transmit-ready at bit 8+s and underrun at bit 12+s, where s is the sequencer number 0 or 1. All other bits read as zero.
- R3: Writing to offset 0x14 clears every defined flag whose data bit is one. A zero data bit leaves its flag unchanged.
- R4: A pulse on `dat_rd_stb[s]` clears the receive-ready flag of sequencer s. It leaves every other flag unchanged.
- R5: A pulse on `dat_wr_stb[s]` clears the transmit-ready flag of sequencer s. It leaves every other flag unchanged.
- R6: Overrun and underrun flags ignore both data strobes. They clear only through a write of one at offset 0x14.
- R7: If an event and a clear of the same flag arrive in the same cycle, the flag is set after that edge. The clear may come from a write of one or from a data strobe.
- R8: Writing to offset 0x10 sets the enable bits whose data bit is one. Writing to offset 0x0C clears them. Reading either offset returns the enable mask, which uses the same bit layout as the status register. Undefined bits always read zero.
- R9: `irq` is high exactly when some status bit and its enable bit are both one. It updates on the clock edge after the flag or mask changes.
- R10: Writes to other offsets change nothing, and reads of other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| evt_rx_rdy | input | NUM_SEQ (2) | Received word available, one bit per sequencer |
| evt_rx_ovr | input | NUM_SEQ (2) | Receive overrun pulse |
| evt_tx_rdy | input | NUM_SEQ (2) | Transmitter ready for a new word |
| evt_tx_und | input | NUM_SEQ (2) | Transmit underrun pulse |
| dat_rd_stb | input | NUM_SEQ (2) | Software read of a sequencer's data register |
| dat_wr_stb | input | NUM_SEQ (2) | Software write of a sequencer's data register |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with its default values, NUM_SEQ = 2 and ADDR_W = 8. This gives eight defined flags. All 256 combinations of simultaneous event pulses can therefore be driven, each followed by a write-one-to-clear. Every enable-mask pattern is written through the set view and then partly removed through the clear view. All 64 pairings of a single flag with a single enable bit are checked on the interrupt line, including its one-cycle lag. Directed cases cover the data-strobe clears, set-over-clear collisions and accesses to unmapped offsets.

// File: rtl/irq_flag_pkg.sv
// Package: shared constants and helpers for the interrupt flag controller.
// Assumes at most four sequencers, because each event kind owns a 4-bit group.
package irq_flag_pkg;
    localparam int REG_W       = 16;
    localparam int KIND_STRIDE = 4;
    localparam int NUM_KINDS   = 4;
    localparam int MAX_SEQ     = KIND_STRIDE;

    typedef enum int {
        K_RX_RDY = 0,
        K_RX_OVR = 1,
        K_TX_RDY = 2,
        K_TX_UND = 3
    } flag_kind_e;

    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_EN_SET = 8'h10;
    localparam logic [7:0] OFS_EN_CLR = 8'h0C;

    // Bit position of a given event kind for a given sequencer.
    function automatic int flag_pos(input int kind, input int seq);
        return kind * KIND_STRIDE + seq;
    endfunction

    // Mask of the defined flag bits for nseq sequencers.
    function automatic logic [REG_W-1:0] valid_mask(input int nseq);
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_KINDS; k++)
            for (int s = 0; s < nseq; s++)
                m[flag_pos(k, s)] = 1'b1;
        return m;
    endfunction

    // Mask of the error flags (overrun and underrun) only.
    function automatic logic [REG_W-1:0] error_mask(input int nseq);
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < nseq; s++) begin
            m[flag_pos(K_RX_OVR, s)] = 1'b1;
            m[flag_pos(K_TX_UND, s)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_bus_decode.sv
// Module: register bus decoder.
// Turns a bus access into one-cycle write enables for the three register
// views, and muxes the read data. Assumes a single-cycle access with no wait states.
module irq_bus_decode
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  stat_q,
    input  logic [REG_W-1:0]  en_q,
    output logic              stat_w1c,
    output logic              en_set_wr,
    output logic              en_clr_wr,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(OFS_EN_CLR);

    logic wr_cyc;
    logic rd_cyc;

    assign wr_cyc = bus_sel && bus_wr;
    assign rd_cyc = bus_sel && !bus_wr;

    // Decode the write strobes for each register view.
    always_comb begin
        stat_w1c  = wr_cyc && (bus_addr == A_STAT);
        en_set_wr = wr_cyc && (bus_addr == A_ESET);
        en_clr_wr = wr_cyc && (bus_addr == A_ECLR);
    end

    // Read mux; unmapped offsets and idle cycles return zero.
    always_comb begin
        rdata = '0;
        if (rd_cyc) begin
            if (bus_addr == A_STAT)
                rdata = stat_q;
            else if (bus_addr == A_ESET || bus_addr == A_ECLR)
                rdata = en_q;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: sticky status flags.
// Each defined bit is set by its event pulse. It is cleared by a write of one
// or, for the ready kinds, by the matching data strobe. A set wins over a
// clear in the same cycle. Undefined bits stay zero.
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int NUM_SEQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEQ-1:0] evt_rx_rdy,
    input  logic [NUM_SEQ-1:0] evt_rx_ovr,
    input  logic [NUM_SEQ-1:0] evt_tx_rdy,
    input  logic [NUM_SEQ-1:0] evt_tx_und,
    input  logic [NUM_SEQ-1:0] dat_rd_stb,
    input  logic [NUM_SEQ-1:0] dat_wr_stb,
    input  logic               w1c_en,
    input  logic [REG_W-1:0]   w1c_data,
    output logic [REG_W-1:0]   stat_q
);
    localparam logic [REG_W-1:0] VALID = valid_mask(NUM_SEQ);

    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] side_v;
    logic [REG_W-1:0] clr_v;

    // Map the per-sequencer event and strobe inputs onto the register layout.
    always_comb begin
        set_v  = '0;
        side_v = '0;
        for (int s = 0; s < NUM_SEQ; s++) begin
            set_v[flag_pos(K_RX_RDY, s)]  = evt_rx_rdy[s];
            set_v[flag_pos(K_RX_OVR, s)]  = evt_rx_ovr[s];
            set_v[flag_pos(K_TX_RDY, s)]  = evt_tx_rdy[s];
            set_v[flag_pos(K_TX_UND, s)]  = evt_tx_und[s];
            side_v[flag_pos(K_RX_RDY, s)] = dat_rd_stb[s];
            side_v[flag_pos(K_TX_RDY, s)] = dat_wr_stb[s];
        end
        clr_v = side_v | (w1c_en ? w1c_data : '0);
    end

    // Flag register: a set beats a clear; undefined bits are masked off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= VALID & (set_v | (stat_q & ~clr_v));
    end
endmodule

// File: rtl/irq_enable_reg.sv
// Module: interrupt enable mask with separate set and clear write views.
// Assumes that a single bus write reaches at most one of the two views.
module irq_enable_reg
    import irq_flag_pkg::*;
#(
    parameter int NUM_SEQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_q
);
    localparam logic [REG_W-1:0] VALID = valid_mask(NUM_SEQ);

    logic [REG_W-1:0] set_m;
    logic [REG_W-1:0] clr_m;

    // Qualify the write data with the view being written.
    always_comb begin
        set_m = set_wr ? wdata : '0;
        clr_m = clr_wr ? wdata : '0;
    end

    // Mask register: OR in the set bits, remove the clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= VALID & ((en_q | set_m) & ~clr_m);
    end
endmodule

// File: rtl/irq_req_merge.sv
// Module: combines the enabled flags into one registered interrupt request.
// Assumes that both inputs come straight from registers.
module irq_req_merge
    import irq_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_q,
    input  logic [REG_W-1:0] en_q,
    output logic             irq
);
    // Register the OR of the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(stat_q & en_q);
    end
endmodule

// File: rtl/irq_flag_ctl.sv
// Module: top of the interrupt flag controller for NUM_SEQ serial sequencers.
// Assumes that event and data-access inputs are one-cycle pulses synchronous
// to clk, and that the bus makes single-cycle accesses.
module irq_flag_ctl
    import irq_flag_pkg::*;
#(
    parameter int NUM_SEQ = 2,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SEQ-1:0] evt_rx_rdy,
    input  logic [NUM_SEQ-1:0] evt_rx_ovr,
    input  logic [NUM_SEQ-1:0] evt_tx_rdy,
    input  logic [NUM_SEQ-1:0] evt_tx_und,
    input  logic [NUM_SEQ-1:0] dat_rd_stb,
    input  logic [NUM_SEQ-1:0] dat_wr_stb,
    output logic               irq
);
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] en_q;
    logic             stat_w1c;
    logic             en_set_wr;
    logic             en_clr_wr;

    irq_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .stat_q    (stat_q),
        .en_q      (en_q),
        .stat_w1c  (stat_w1c),
        .en_set_wr (en_set_wr),
        .en_clr_wr (en_clr_wr),
        .rdata     (bus_rdata)
    );

    irq_flag_bank #(.NUM_SEQ(NUM_SEQ)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_rx_rdy (evt_rx_rdy),
        .evt_rx_ovr (evt_rx_ovr),
        .evt_tx_rdy (evt_tx_rdy),
        .evt_tx_und (evt_tx_und),
        .dat_rd_stb (dat_rd_stb),
        .dat_wr_stb (dat_wr_stb),
        .w1c_en     (stat_w1c),
        .w1c_data   (bus_wdata),
        .stat_q     (stat_q)
    );

    irq_enable_reg #(.NUM_SEQ(NUM_SEQ)) en_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (en_set_wr),
        .clr_wr (en_clr_wr),
        .wdata  (bus_wdata),
        .en_q   (en_q)
    );

    irq_req_merge merge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_q (stat_q),
        .en_q   (en_q),
        .irq    (irq)
    );
endmodule

// File: rtl/irq_flag_ctl_chk.sv
// Module: assertion checker, bound to irq_flag_ctl.
// Observes the ports and the internal status and enable registers.
module irq_flag_ctl_chk
    import irq_flag_pkg::*;
#(
    parameter int NUM_SEQ = 2,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [NUM_SEQ-1:0] evt_rx_rdy,
    input logic [NUM_SEQ-1:0] evt_rx_ovr,
    input logic [NUM_SEQ-1:0] evt_tx_rdy,
    input logic [NUM_SEQ-1:0] evt_tx_und,
    input logic [NUM_SEQ-1:0] dat_rd_stb,
    input logic [NUM_SEQ-1:0] dat_wr_stb,
    input logic [REG_W-1:0]   stat_q,
    input logic [REG_W-1:0]   en_q,
    input logic               irq
);
    localparam logic [REG_W-1:0] ERR = error_mask(NUM_SEQ);

    logic [REG_W-1:0] ev_vec;
    logic             wr_stat;
    logic             wr_en;

    // Rebuild the event vector from the ports, independently of the flag bank.
    always_comb begin
        ev_vec = '0;
        for (int s = 0; s < NUM_SEQ; s++) begin
            ev_vec[K_RX_RDY * KIND_STRIDE + s] = evt_rx_rdy[s];
            ev_vec[K_RX_OVR * KIND_STRIDE + s] = evt_rx_ovr[s];
            ev_vec[K_TX_RDY * KIND_STRIDE + s] = evt_tx_rdy[s];
            ev_vec[K_TX_UND * KIND_STRIDE + s] = evt_tx_und[s];
        end
        wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_en   = bus_sel && bus_wr &&
                  (bus_addr == ADDR_W'(OFS_EN_SET) || bus_addr == ADDR_W'(OFS_EN_CLR));
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ((ev_vec & bus_wdata) != '0)) |=>
        ((stat_q & $past(ev_vec & bus_wdata)) == $past(ev_vec & bus_wdata)));

    a_r3_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec == '0 && !wr_stat && dat_rd_stb == '0 && dat_wr_stb == '0)
        |=> $stable(stat_q));

    a_r6_err_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat) |=> ((stat_q & ERR) & $past(stat_q & ERR)) == $past(stat_q & ERR));

    a_r8_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(en_q));

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(stat_q) & $past(en_q))));

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        a_r4_rd_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
            (dat_rd_stb[g] && !evt_rx_rdy[g]) |=> !stat_q[K_RX_RDY * KIND_STRIDE + g]);
        a_r5_wr_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
            (dat_wr_stb[g] && !evt_tx_rdy[g]) |=> !stat_q[K_TX_RDY * KIND_STRIDE + g]);
    end
endmodule

bind irq_flag_ctl irq_flag_ctl_chk #(.NUM_SEQ(NUM_SEQ), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_rx_rdy (evt_rx_rdy),
    .evt_rx_ovr (evt_rx_ovr),
    .evt_tx_rdy (evt_tx_rdy),
    .evt_tx_und (evt_tx_und),
    .dat_rd_stb (dat_rd_stb),
    .dat_wr_stb (dat_wr_stb),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .irq        (irq)
);

// File: tb/irq_flag_ctl_tb_top.sv
// Bench: sweeps over the 8 flags of a two-sequencer build; expected values
// are computed from the register layout given in the requirements.
module irq_flag_ctl_tb_top;
    localparam int PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_ESET = 8'h10;
    localparam logic [7:0] A_ECLR = 8'h0C;

    logic        clk;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [1:0]  evt_rx_rdy;
    logic [1:0]  evt_rx_ovr;
    logic [1:0]  evt_tx_rdy;
    logic [1:0]  evt_tx_und;
    logic [1:0]  dat_rd_stb;
    logic [1:0]  dat_wr_stb;
    logic        irq;

    int n_run;
    int n_fail;

    irq_flag_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rx_rdy(evt_rx_rdy), .evt_rx_ovr(evt_rx_ovr),
        .evt_tx_rdy(evt_tx_rdy), .evt_tx_und(evt_tx_und),
        .dat_rd_stb(dat_rd_stb), .dat_wr_stb(dat_wr_stb), .irq(irq)
    );

    initial begin
        clk = 1'b0;
        forever #(PERIOD / 2) clk = ~clk;
    end

    // Flag index k (0..7): kind k/2 in {rx_rdy, rx_ovr, tx_rdy, tx_und}, sequencer k%2.
    function automatic logic [15:0] expand(input logic [7:0] m);
        logic [15:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) r[(k / 2) * 4 + (k % 2)] = m[k];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negative edge to the next.
    task automatic step(input logic [7:0] ev, input logic do_wr, input logic [7:0] a,
                        input logic [15:0] d, input logic [1:0] rds, input logic [1:0] wrs);
        evt_rx_rdy = ev[1:0]; evt_rx_ovr = ev[3:2];
        evt_tx_rdy = ev[5:4]; evt_tx_und = ev[7:6];
        bus_sel = do_wr; bus_wr = do_wr; bus_addr = a; bus_wdata = d;
        dat_rd_stb = rds; dat_wr_stb = wrs;
        @(negedge clk);
        evt_rx_rdy = '0; evt_rx_ovr = '0; evt_tx_rdy = '0; evt_tx_und = '0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        dat_rd_stb = '0; dat_wr_stb = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        step(8'h00, 1'b1, a, d, 2'b00, 2'b00);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic clear_all();
        wr(A_STAT, 16'hFFFF);
        wr(A_ECLR, 16'hFFFF);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp_s;
        n_run = 0; n_fail = 0;
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        evt_rx_rdy = '0; evt_rx_ovr = '0; evt_tx_rdy = '0; evt_tx_und = '0;
        dat_rd_stb = '0; dat_wr_stb = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_STAT, v); chk("R1 status", v, 16'h0);
        rd(A_ESET, v); chk("R1 enable", v, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);

        // R2, R3: all event combinations, then a partial write-one-to-clear
        for (int m = 0; m < 256; m++) begin
            clear_all();
            step(8'(m), 1'b0, 8'h00, 16'h0, 2'b00, 2'b00);
            exp_s = expand(8'(m));
            rd(A_STAT, v); chk("R2 event set", v, exp_s);
            wr(A_STAT, expand(8'(m) ^ 8'hA5) | 16'hCCCC);
            exp_s = exp_s & ~expand(8'(m) ^ 8'hA5);
            rd(A_STAT, v); chk("R3 w1c", v, exp_s);
            wr(A_STAT, 16'h0000);
            rd(A_STAT, v); chk("R3 zero write", v, exp_s);
        end

        // R4, R5, R6: data strobes per sequencer
        for (int s = 0; s < 2; s++) begin
            clear_all();
            step(8'hFF, 1'b0, 8'h00, 16'h0, 2'b00, 2'b00);
            step(8'h00, 1'b0, 8'h00, 16'h0, 2'(1 << s), 2'b00);
            exp_s = 16'h3333 & ~(16'h0001 << s);
            rd(A_STAT, v); chk("R4 rd strobe", v, exp_s);
            step(8'h00, 1'b0, 8'h00, 16'h0, 2'b00, 2'(1 << s));
            exp_s = exp_s & ~(16'h0100 << s);
            rd(A_STAT, v); chk("R5 wr strobe", v, exp_s);
            step(8'h00, 1'b0, 8'h00, 16'h0, 2'b11, 2'b11);
            rd(A_STAT, v); chk("R6 error flags kept", v, 16'h3030);
        end

        // R7: set wins over a same-cycle clear
        clear_all();
        step(8'hFF, 1'b1, A_STAT, 16'hFFFF, 2'b00, 2'b00);
        rd(A_STAT, v); chk("R7 set vs w1c", v, 16'h3333);
        wr(A_STAT, 16'hFFFF);
        step(8'h33, 1'b0, 8'h00, 16'h0, 2'b11, 2'b11);
        rd(A_STAT, v); chk("R7 set vs strobe", v, 16'h0303);

        // R8: enable set and clear views over all patterns
        for (int m = 0; m < 256; m++) begin
            wr(A_ECLR, 16'hFFFF);
            wr(A_ESET, expand(8'(m)) | 16'hCCCC);
            rd(A_ESET, v); chk("R8 set view", v, expand(8'(m)));
            rd(A_ECLR, v); chk("R8 clear view", v, expand(8'(m)));
            wr(A_ECLR, expand(8'(m) & 8'h0F));
            rd(A_ESET, v); chk("R8 after clear", v, expand(8'(m) & 8'hF0));
        end

        // R9: single flag against single enable, with one-cycle lag
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                clear_all();
                step(8'(1 << i), 1'b0, 8'h00, 16'h0, 2'b00, 2'b00);
                wr(A_ESET, expand(8'(1 << j)));
                chk("R9 irq lag", {15'h0, irq}, 16'h0);
                @(negedge clk);
                chk("R9 irq value", {15'h0, irq}, {15'h0, (i == j)});
            end
        end

        // R10: unmapped offsets
        clear_all();
        step(8'hFF, 1'b0, 8'h00, 16'h0, 2'b00, 2'b00);
        wr(A_ESET, 16'h0F0F);
        wr(8'h18, 16'hFFFF);
        wr(8'h00, 16'hFFFF);
        rd(A_STAT, v); chk("R10 status kept", v, 16'h3333);
        rd(A_ESET, v); chk("R10 enable kept", v, 16'h0303);
        rd(8'h18, v);  chk("R10 unmapped read", v, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule